// File: doc/BRIEF.md
# Debug Trigger Sticky Status Register

This block gathers the outcome signals of an on-chip debug trigger unit into one 32-bit status word. The trigger unit's own qualification logic, counters and sequencer live elsewhere and hand over single-cycle event pulses plus a few level signals. The block turns each pulse into a sticky flag that stays set until software clears it. The word also shows the sequencer's mode and an encoded view of its current state.

Software reads the status word over a simple register bus. It clears flags by writing ones to a separate, write-only clear register at its own address. Writing to the status word itself has no effect. If an event and a clear request for the same flag land in the same cycle, the flag stays set, so no event is lost. Four counter flags follow either a generic meaning or a watermark meaning, chosen for each pair of counters. The state field shows either one four-state machine or two two-state machines.

Top module: `dbg_sticky_status`

## Requirements
- R1: After a synchronous active-low reset, every bit of the status word reads 0 while `sm_mode` and `sm_en` are 0.
- R2: Bit 31 (halt flag) is set one clock after an `evt_halt` pulse. It is cleared by a bus write of a word with bit 0 set to the clear register at address 0x4.
- R3: Bit 30 (trace-end flag) is set by `evt_trace_end` and bit 23 (trace-trigger flag) by `evt_trace_trig`, each on its own. One write with bit 1 set to the clear register clears both.
- R4: Bit 22 (debug-interrupt flag) is set by `evt_irq` and cleared by a write with bit 2 set to the clear register.
- R5: When a set event and a clear request for the same flag arrive in the same cycle, the flag is set afterwards.
- R6: With the pair's `wm_mode` bit at 0 (generic), status bit 24+n is set by `cnt_wrap[n]` and cleared by a write with bit 4+n set to the clear register.
- R7: A counter flag also clears on any cycle where the counter that governs it has its `cnt_en` bit low. A set in that same cycle still wins.
- R8: With `wm_mode[p]` at 1, flag 2p+1 is set by `wm_close[p]` and ignores `cnt_wrap[2p+1]`, and its governing counter is 2p. With `wm_mode[p]` at 0, `wm_close[p]` has no effect.
- R9: Status bit 9 always equals the `sm_mode` input.
- R10: With `sm_mode`=0, bits 8:5 read 0000 when `sm_en` is 0, and otherwise read 0001, 0010, 0100 or 1000 for `sm_state` 0 to 3.
- R11: With `sm_mode`=1 and `sm_en`=1, bits 6:5 read 01 or 10 for `sm_m0_st` 0 or 1, and bits 8:7 read 01 or 10 for `sm_m1_st` 0 or 1. Disabled reads 0000.
- R12: Bits 29:28, 21:10 and 4:0 always read 0. Writes to the status address change nothing. Reads of the clear register return 0, and `bus_rdata` is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_halt | input | 1 | Qualified stop-trigger pulse |
| evt_trace_end | input | 1 | Trace-end trigger pulse |
| evt_trace_trig | input | 1 | Trace-trigger pulse |
| evt_irq | input | 1 | Qualified interrupt-trigger pulse |
| cnt_wrap | input | 4 | Per-counter wrap-past-zero pulse |
| cnt_en | input | 4 | Per-counter enable level |
| wm_mode | input | 2 | Watermark mode for each counter pair |
| wm_close | input | 2 | Watermark window end pulse for each pair |
| sm_mode | input | 1 | Sequencer mode: 0 single four-state, 1 dual two-state |
| sm_en | input | 1 | Sequencer enabled |
| sm_state | input | 2 | Current state index in single mode |
| sm_m0_st | input | 1 | Machine 0 state in dual mode |
| sm_m1_st | input | 1 | Machine 1 state in dual mode |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 4 | Byte address: 0x0 status, 0x4 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
The sticky flags are driven in several ways: a lone event, an event followed by a clear, an event that coincides with a clear, and a clear aimed at a different flag. Together these separate set-wins priority, the shared trace clear and leakage between flags. The counter flags are tried in both modes and against both clear routes: a bus write and a counter disable. This shows which source feeds the odd flag in each mode, and which counter's enable governs it. The state field is swept through every single-mode index and every dual-mode pair, so a bit transposed in the encoding shows up.

// File: rtl/dss_pkg.sv
// Shared constants for the debug sticky status block: the bus map, the
// positions of the status fields and the bit layout of the clear register.
package dss_pkg;
    localparam int unsigned BUS_AW  = 4;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CNT_N   = 4;
    localparam int unsigned PAIR_N  = CNT_N / 2;

    localparam logic [BUS_AW-1:0] ADDR_STATUS = 4'h0;
    localparam logic [BUS_AW-1:0] ADDR_CLEAR  = 4'h4;

    // status word field positions
    localparam int unsigned SB_HALT  = 31;
    localparam int unsigned SB_TEND  = 30;
    localparam int unsigned SB_UDF   = 24;
    localparam int unsigned SB_TTRIG = 23;
    localparam int unsigned SB_IRQ   = 22;
    localparam int unsigned SB_SMM   = 9;
    localparam int unsigned SB_ST    = 5;

    // clear register bit positions
    localparam int unsigned CB_HALT  = 0;
    localparam int unsigned CB_TRACE = 1;
    localparam int unsigned CB_IRQ   = 2;
    localparam int unsigned CB_UDF   = 4;

    localparam logic [DATA_W-1:0] RSV_MASK = 32'h303F_FC1F;

    typedef struct packed {
        logic             halt;
        logic             trace;
        logic             irq;
        logic [CNT_N-1:0] udf;
    } clr_req_t;
endpackage

// File: rtl/dss_bus_decode.sv
// Register bus front end. It turns a write to the clear address into a
// one-cycle clear request and returns the status word on reads.
// Assumes one access per cycle. Writes to any other address are dropped.
module dss_bus_decode
    import dss_pkg::*;
(
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] status,
    output clr_req_t          clr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic clr_hit;

    // the clear request lasts only as long as the write strobe
    always_comb begin
        clr_hit   = bus_wr && (bus_addr == ADDR_CLEAR);
        clr.halt  = clr_hit && bus_wdata[CB_HALT];
        clr.trace = clr_hit && bus_wdata[CB_TRACE];
        clr.irq   = clr_hit && bus_wdata[CB_IRQ];
        clr.udf   = clr_hit ? bus_wdata[CB_UDF +: CNT_N] : '0;
    end

    // read mux: only the status address returns data
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && (bus_addr == ADDR_STATUS))
            bus_rdata = status & ~RSV_MASK;
    end
endmodule

// File: rtl/dss_event_flags.sv
// Four sticky event flags: halt, trace end, trace trigger, interrupt.
// A set pulse in the same cycle as a clear request leaves the flag set.
// The trace end and trace trigger flags share one clear request.
module dss_event_flags
    import dss_pkg::*;
#(
    parameter int unsigned EVT_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_set,
    input  clr_req_t         clr,
    output logic [EVT_N-1:0] flag_q
);
    // index map: 0 halt, 1 trace end, 2 trace trigger, 3 interrupt
    logic [EVT_N-1:0] evt_clr;

    // route clear requests; both trace flags take the shared trace clear
    always_comb begin
        evt_clr    = '0;
        evt_clr[0] = clr.halt;
        evt_clr[1] = clr.trace;
        evt_clr[2] = clr.trace;
        evt_clr[3] = clr.irq;
    end

    for (genvar i = 0; i < EVT_N; i++) begin : g_flag
        // sticky flag with set priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else
                flag_q[i] <= evt_set[i] | (flag_q[i] & ~evt_clr[i]);
        end
    end
endmodule

// File: rtl/dss_udf_flags.sv
// Counter flags. Even flags always follow their own counter's wrap.
// An odd flag follows its own counter in generic mode. In watermark mode
// it follows the window end of its pair and is governed by the pair's
// even counter. A flag clears on a bus clear or while its governing
// counter is disabled, but a set in the same cycle wins.
module dss_udf_flags #(
    parameter int unsigned CNT_N = 4,
    localparam int unsigned PAIR_N = CNT_N / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_N-1:0]  cnt_wrap,
    input  logic [CNT_N-1:0]  cnt_en,
    input  logic [PAIR_N-1:0] wm_mode,
    input  logic [PAIR_N-1:0] wm_close,
    input  logic [CNT_N-1:0]  clr_udf,
    output logic [CNT_N-1:0]  udf_q
);
    logic [CNT_N-1:0] set_src;
    logic [CNT_N-1:0] kill;

    for (genvar n = 0; n < CNT_N; n++) begin : g_cnt
        if (n % 2 == 0) begin : g_even
            // even flag: own wrap, own enable
            always_comb begin
                set_src[n] = cnt_wrap[n];
                kill[n]    = clr_udf[n] | ~cnt_en[n];
            end
        end else begin : g_odd
            // odd flag: source and governing counter picked by pair mode
            always_comb begin
                if (wm_mode[n/2]) begin
                    set_src[n] = wm_close[n/2];
                    kill[n]    = clr_udf[n] | ~cnt_en[n-1];
                end else begin
                    set_src[n] = cnt_wrap[n];
                    kill[n]    = clr_udf[n] | ~cnt_en[n];
                end
            end
        end

        // sticky flag with set priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                udf_q[n] <= 1'b0;
            else
                udf_q[n] <= set_src[n] | (udf_q[n] & ~kill[n]);
        end
    end
endmodule

// File: rtl/dss_state_enc.sv
// Encodes the sequencer state for the status word. Single mode gives a
// one-hot code of the four-state index. Dual mode gives a two-bit code
// per machine: 01 for state 0, 10 for state 1. Disabled gives all zero.
module dss_state_enc #(
    parameter int unsigned ST_W = 4,
    localparam int unsigned IDX_W = $clog2(ST_W),
    localparam int unsigned HALF  = ST_W / 2
) (
    input  logic             sm_mode,
    input  logic             sm_en,
    input  logic [IDX_W-1:0] sm_state,
    input  logic             sm_m0_st,
    input  logic             sm_m1_st,
    output logic [ST_W-1:0]  st_code
);
    // select encoding by mode
    always_comb begin
        st_code = '0;
        if (sm_en) begin
            if (!sm_mode) begin
                st_code[sm_state] = 1'b1;
            end else begin
                st_code[HALF-1:0]    = sm_m0_st ? 2'b10 : 2'b01;
                st_code[ST_W-1:HALF] = sm_m1_st ? 2'b10 : 2'b01;
            end
        end
    end
endmodule

// File: rtl/dbg_sticky_status.sv
// Top of the debug sticky status register. It puts together the event
// flags, counter flags, mode shadow and state code into one 32-bit word,
// readable over a simple bus and cleared by writes to a clear register.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module dbg_sticky_status
    import dss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_halt,
    input  logic              evt_trace_end,
    input  logic              evt_trace_trig,
    input  logic              evt_irq,
    input  logic [CNT_N-1:0]  cnt_wrap,
    input  logic [CNT_N-1:0]  cnt_en,
    input  logic [PAIR_N-1:0] wm_mode,
    input  logic [PAIR_N-1:0] wm_close,
    input  logic              sm_mode,
    input  logic              sm_en,
    input  logic [1:0]        sm_state,
    input  logic              sm_m0_st,
    input  logic              sm_m1_st,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int unsigned EVT_N = 4;
    localparam int unsigned ST_W  = 4;

    clr_req_t          clr;
    logic [EVT_N-1:0]  evt_q;
    logic [CNT_N-1:0]  udf_q;
    logic [ST_W-1:0]   st_code;
    logic [DATA_W-1:0] status_w;

    dss_bus_decode i_bus (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status    (status_w),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    dss_event_flags #(.EVT_N(EVT_N)) i_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set ({evt_irq, evt_trace_trig, evt_trace_end, evt_halt}),
        .clr     (clr),
        .flag_q  (evt_q)
    );

    dss_udf_flags #(.CNT_N(CNT_N)) i_udf (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_wrap (cnt_wrap),
        .cnt_en   (cnt_en),
        .wm_mode  (wm_mode),
        .wm_close (wm_close),
        .clr_udf  (clr.udf),
        .udf_q    (udf_q)
    );

    dss_state_enc #(.ST_W(ST_W)) i_st (
        .sm_mode  (sm_mode),
        .sm_en    (sm_en),
        .sm_state (sm_state),
        .sm_m0_st (sm_m0_st),
        .sm_m1_st (sm_m1_st),
        .st_code  (st_code)
    );

    // assemble the status word; unused positions stay zero
    always_comb begin
        status_w                   = '0;
        status_w[SB_HALT]          = evt_q[0];
        status_w[SB_TEND]          = evt_q[1];
        status_w[SB_TTRIG]         = evt_q[2];
        status_w[SB_IRQ]           = evt_q[3];
        status_w[SB_UDF +: CNT_N]  = udf_q;
        status_w[SB_SMM]           = sm_mode;
        status_w[SB_ST +: ST_W]    = st_code;
    end
endmodule

// File: rtl/dbg_sticky_status_chk.sv
// Property checker for the debug sticky status register, bound to the top.
// It watches the bus, the event inputs and the assembled status word.
module dbg_sticky_status_chk
    import dss_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              evt_halt,
    input logic              evt_trace_end,
    input logic              evt_trace_trig,
    input logic              evt_irq,
    input logic              sm_mode,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] status
);
    logic wr_clr;
    assign wr_clr = bus_wr && (bus_addr == ADDR_CLEAR);

    p_halt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_halt |=> status[SB_HALT]);

    p_halt_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[CB_HALT] && !evt_halt) |=> !status[SB_HALT]);

    p_trace_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[CB_TRACE] && !evt_trace_end && !evt_trace_trig)
        |=> (!status[SB_TEND] && !status[SB_TTRIG]));

    p_irq_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_irq && wr_clr && bus_wdata[CB_IRQ]) |=> status[SB_IRQ]);

    p_mode_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_SMM] == sm_mode);

    p_single_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sm_mode |-> $onehot0(status[SB_ST +: 4]));

    p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSV_MASK) == '0);

    p_clear_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_CLEAR) |-> bus_rdata == '0);
endmodule

bind dbg_sticky_status dbg_sticky_status_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_halt       (evt_halt),
    .evt_trace_end  (evt_trace_end),
    .evt_trace_trig (evt_trace_trig),
    .evt_irq        (evt_irq),
    .sm_mode        (sm_mode),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .status         (status_w)
);

// File: tb/test_dbg_sticky_status.sv
module test_dbg_sticky_status;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_halt = 0, evt_trace_end = 0, evt_trace_trig = 0, evt_irq = 0;
    logic [3:0]  cnt_wrap = '0;
    logic [3:0]  cnt_en = 4'hF;
    logic [1:0]  wm_mode = '0, wm_close = '0;
    logic        sm_mode = 0, sm_en = 0;
    logic [1:0]  sm_state = '0;
    logic        sm_m0_st = 0, sm_m1_st = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_sticky_status i_dbg_sticky_status (
        .clk(clk), .rst_n(rst_n),
        .evt_halt(evt_halt), .evt_trace_end(evt_trace_end),
        .evt_trace_trig(evt_trace_trig), .evt_irq(evt_irq),
        .cnt_wrap(cnt_wrap), .cnt_en(cnt_en),
        .wm_mode(wm_mode), .wm_close(wm_close),
        .sm_mode(sm_mode), .sm_en(sm_en), .sm_state(sm_state),
        .sm_m0_st(sm_m0_st), .sm_m1_st(sm_m1_st),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // read a bus address just after a falling edge
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 0; bus_addr = '0;
    endtask

    task automatic status_is(input string tag, input logic [31:0] exp);
        logic [31:0] d;
        rd(4'h0, d);
        check(tag, d, exp);
    endtask

    // one clock: events and/or a write issued together, then released
    task automatic cyc(input logic h, input logic te, input logic tt, input logic ir,
                       input logic [3:0] wr_cw, input logic wr_en, input logic [3:0] a,
                       input logic [31:0] wd);
        @(negedge clk);
        evt_halt = h; evt_trace_end = te; evt_trace_trig = tt; evt_irq = ir;
        cnt_wrap = wr_cw; bus_wr = wr_en; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        evt_halt = 0; evt_trace_end = 0; evt_trace_trig = 0; evt_irq = 0;
        cnt_wrap = '0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        status_is("R1 reset value", 32'h0);
        rd(4'h4, d);
        check("R12 clear register reads zero", d, 32'h0);
    endtask

    task automatic t_halt;
        cyc(1,0,0,0, 4'h0, 0, 4'h0, 0);
        status_is("R2 halt set", 32'h8000_0000);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_0004);
        status_is("R2 other clear leaves halt", 32'h8000_0000);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_0001);
        status_is("R2 halt cleared", 32'h0);
    endtask

    task automatic t_trace;
        cyc(0,1,0,0, 4'h0, 0, 4'h0, 0);
        status_is("R3 trace end only", 32'h4000_0000);
        cyc(0,0,1,0, 4'h0, 0, 4'h0, 0);
        status_is("R3 trace trig added", 32'h4080_0000);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_0002);
        status_is("R3 shared clear", 32'h0);
    endtask

    task automatic t_irq;
        cyc(0,0,0,1, 4'h0, 0, 4'h0, 0);
        status_is("R4 irq set", 32'h0040_0000);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_0004);
        status_is("R4 irq cleared", 32'h0);
    endtask

    task automatic t_set_wins;
        cyc(1,1,1,1, 4'h1, 1, 4'h4, 32'h0000_00F7);
        status_is("R5 set beats clear", 32'hC1C0_0000);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_00F7);
        status_is("R5 later clear works", 32'h0);
    endtask

    task automatic t_udf_generic;
        cyc(0,0,0,0, 4'h5, 0, 4'h0, 0);
        status_is("R6 wraps 0 and 2", 32'h0500_0000);
        cyc(0,0,0,0, 4'hA, 0, 4'h0, 0);
        status_is("R6 wraps 1 and 3", 32'h0F00_0000);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_0060);
        status_is("R6 clear flags 1 and 2", 32'h0900_0000);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_0090);
        status_is("R6 clear rest", 32'h0);
    endtask

    task automatic t_udf_disable;
        @(negedge clk); cnt_wrap = 4'h4; cnt_en = 4'hB;
        @(negedge clk); cnt_wrap = '0;
        status_is("R7 set wins over disable", 32'h0400_0000);
        @(negedge clk); cnt_en = 4'hF;
        status_is("R7 disable clears", 32'h0);
    endtask

    task automatic t_watermark;
        wm_mode = 2'b01;
        cyc(0,0,0,0, 4'h2, 0, 4'h0, 0);
        status_is("R8 wrap ignored on odd flag", 32'h0);
        @(negedge clk); wm_close = 2'b01;
        @(negedge clk); wm_close = '0;
        status_is("R8 window end sets flag 1", 32'h0200_0000);
        @(negedge clk); cnt_en = 4'hD;
        @(negedge clk); cnt_en = 4'hF;
        status_is("R8 own enable ignored in watermark", 32'h0200_0000);
        @(negedge clk); cnt_en = 4'hE;
        @(negedge clk); cnt_en = 4'hF;
        status_is("R8 pair counter disable clears", 32'h0);
        @(negedge clk); wm_close = 2'b10;
        @(negedge clk); wm_close = '0;
        status_is("R8 window end ignored in generic", 32'h0);
        wm_mode = 2'b00;
    endtask

    task automatic t_state;
        @(negedge clk); sm_mode = 0; sm_en = 0; sm_state = 2'd2;
        status_is("R10 disabled", 32'h0);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); sm_en = 1; sm_state = s[1:0];
            status_is("R10 single one-hot", 32'(1) << (5 + s));
        end
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); sm_mode = 1; sm_m0_st = s[0]; sm_m1_st = s[1];
            status_is("R11 dual code", 32'h200 |
                      ((s[0] ? 32'h2 : 32'h1) << 5) | ((s[1] ? 32'h2 : 32'h1) << 7));
        end
        @(negedge clk); sm_en = 0;
        status_is("R9 mode shadow with dual disabled", 32'h200);
        @(negedge clk); sm_mode = 0;
    endtask

    task automatic t_bus_misc;
        logic [31:0] d;
        cyc(1,0,0,0, 4'h0, 0, 4'h0, 0);
        cyc(0,0,0,0, 4'h0, 1, 4'h0, 32'hFFFF_FFFF);
        status_is("R12 write to status ignored", 32'h8000_0000);
        #1 check("R12 idle rdata zero", bus_rdata, 32'h0);
        rd(4'h4, d);
        check("R12 clear reads zero with flag set", d, 32'h0);
        cyc(0,0,0,0, 4'h0, 1, 4'h4, 32'h0000_0001);
        status_is("R2 cleanup", 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_halt();
        t_trace();
        t_irq();
        t_set_wins();
        t_udf_generic();
        t_udf_disable();
        t_watermark();
        t_state();
        t_bus_misc();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule